// File: doc/BRIEF.md
# Compare-Match Interval Timer

A register-programmed up-counting timer for scheduling one-shot events. Software enables the block, chooses the source of count ticks and a divide ratio, and then arranges an event by reading the live count, adding a delta and writing the sum into the compare register. When the count steps onto the compare value, a sticky match flag is raised and an interrupt line can follow it.

The count width is a parameter and defaults to 32 bits. All compare arithmetic is modulo 2^CNT_W, so an event may be placed beyond the point where the count wraps. A mode bit selects between two behaviours. In the first, the count runs freely through a match. In the second, it reloads to zero just after a match and produces periodic matches.

Register access is by a single write strobe with a byte offset. Read data is combinational from the offset.

Top module: `cmp_timer`

## Requirements
- R1: Control bit 0 enables counting. While it is 0, the counter and the internal tick divider are cleared and held at 0. Writing 0 to control and then 0 to the prescaler therefore leaves the timer stopped at a known state.
- R2: Byte offsets are control 0x00, prescaler 0x04, compare 0x08, counter 0x10 and status 0x14. Reads return the register contents, zero-extended to 32 bits. The counter cannot be written. Any other offset reads as 0 and ignores writes.
- R3: Control bit 1 selects the tick source. When it is 1, every clock cycle is a tick. When it is 0, only cycles with `ref_tick` high are ticks.
- R4: The prescaler value P (PRE_W bits) advances the counter once every P+1 ticks. P = 0 gives one count per tick. Writing the prescaler restarts the divider.
- R5: Status bit 0 (match flag) sets on the clock edge where the counter steps into the compare value. A compare value written equal to a count that is not moving does not set the flag.
- R6: With control bit 8 set (free-run), the counter keeps incrementing through a match and wraps from 2^CNT_W-1 to 0.
- R7: With control bit 8 clear (restart), the counter becomes 0 on the clock edge after the one that produced the match, and counting then resumes from 0.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. Status bit 1 (capture flag) always reads 0.
- R9: `irq` is the match flag ANDed with control bit 4. The flag still sets while bit 4 is 0, and `irq` stays high until the flag is cleared.
- R10: After reset, all registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| ref_tick | input | 1 | Alternate tick source, sampled when control bit 1 is 0 |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Level interrupt: match flag AND interrupt gate |

## Verification
The bench places a compare target past the wrap point, reached by reading the count and adding a delta. A design that matched with a plain magnitude comparison, or that saturated instead of wrapping, would raise the flag at once or never. It writes a compare value equal to a frozen count and checks that the flag stays clear until the counter comes round through the full range. A level-triggered comparator would set the flag immediately. It measures the exact edge of the restart reload and the exact divide ratio of the prescaler, which catches an off-by-one such as dividing by P or reloading on the match edge itself. It also confirms that the flag sets with the interrupt gated off and that a zero written to status does not clear it.

// File: rtl/tmr_pkg.sv
// Package: shared offsets, bit positions and the control-register type
// for the compare-match timer. Assumes byte addressing of 32-bit words.
package tmr_pkg;
    localparam int OFF_CTL = 'h00;
    localparam int OFF_PRE = 'h04;
    localparam int OFF_CMP = 'h08;
    localparam int OFF_CNT = 'h10;
    localparam int OFF_STS = 'h14;

    localparam int CTL_EN   = 0;
    localparam int CTL_SRC  = 1;
    localparam int CTL_IEN  = 4;
    localparam int CTL_FREE = 8;

    localparam int STS_CMP = 0;
    localparam int STS_CAP = 1;

    typedef struct packed {
        logic freerun;
        logic ien;
        logic src;
        logic en;
    } ctl_t;
endpackage

// File: rtl/tmr_prescale.sv
// Tick divider: chooses the tick source and issues one count step every
// (div+1) ticks. Assumes div only changes together with a restart pulse.
module tmr_prescale #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             src_sel,
    input  logic             ref_tick,
    input  logic [PRE_W-1:0] div,
    input  logic             restart,
    output logic             step
);
    logic             tick;
    logic [PRE_W-1:0] pre_q;

    // Select the tick source: every cycle or the external tick.
    always_comb tick = src_sel ? 1'b1 : ref_tick;

    // Emit a step when the divider reaches its terminal value.
    always_comb step = en && tick && (pre_q == div);

    // Divider state: cleared while off or when the ratio is rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            pre_q <= '0;
        end else if (tick) begin
            if (pre_q == div) pre_q <= '0;
            else              pre_q <= pre_q + 1'b1;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= div); // R4
    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pre_q == '0)); // R1
endmodule

// File: rtl/tmr_count.sv
// Counter core: increments on each step, detects the step into the compare
// value and, in restart mode, reloads to zero the edge after a match.
module tmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             freerun,
    input  logic             step,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic             at_match_q;
    logic             reload;

    // Next count value, wrapping modulo 2^CNT_W.
    always_comb nxt = cnt_q + 1'b1;

    // Reload is pending one edge after a match, in restart mode only.
    always_comb reload = at_match_q && !freerun;

    // A match is the step that lands the counter on the compare value.
    always_comb hit = step && !reload && (nxt == cmp);

    // Count register and the one-cycle match memory.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q      <= '0;
            at_match_q <= 1'b0;
        end else begin
            at_match_q <= hit;
            if (reload)    cnt_q <= '0;
            else if (step) cnt_q <= nxt;
        end
    end

    always_comb cnt = cnt_q;

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && !reload) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
    AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step && !reload) |=> $stable(cnt_q)); // R4
    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && reload) |=> (cnt_q == '0)); // R7
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/tmr_regs.sv
// Register file: control, prescaler, compare and the status flag, plus the
// read mux and interrupt gate. Assumes one write per cycle at a byte offset.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PRE_W  = 12,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              hit,
    input  logic [CNT_W-1:0]  cnt,
    output ctl_t              ctl,
    output logic [PRE_W-1:0]  pre_val,
    output logic              pre_wr,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [31:0]       rdata,
    output logic              irq
);
    logic sel_ctl, sel_pre, sel_cmp, sel_cnt, sel_sts;
    logic flag_q;
    logic clr_req;

    // Decode the byte offset into register selects.
    always_comb begin
        sel_ctl = (addr == ADDR_W'(OFF_CTL));
        sel_pre = (addr == ADDR_W'(OFF_PRE));
        sel_cmp = (addr == ADDR_W'(OFF_CMP));
        sel_cnt = (addr == ADDR_W'(OFF_CNT));
        sel_sts = (addr == ADDR_W'(OFF_STS));
    end

    // Divider restart strobe on any prescaler write.
    always_comb pre_wr = wr_en && sel_pre;

    // Write-one-to-clear request for the match flag.
    always_comb clr_req = wr_en && sel_sts && wdata[STS_CMP];

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl     <= '0;
            pre_val <= '0;
            cmp_val <= '0;
        end else if (wr_en) begin
            if (sel_ctl) begin
                ctl.en      <= wdata[CTL_EN];
                ctl.src     <= wdata[CTL_SRC];
                ctl.ien     <= wdata[CTL_IEN];
                ctl.freerun <= wdata[CTL_FREE];
            end
            if (sel_pre) pre_val <= wdata[PRE_W-1:0];
            if (sel_cmp) cmp_val <= wdata[CNT_W-1:0];
        end
    end

    // Sticky match flag; a new match wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (hit)     flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    // Read mux, zero-extending narrow fields.
    always_comb begin
        rdata = '0;
        if (sel_ctl) begin
            rdata[CTL_EN]   = ctl.en;
            rdata[CTL_SRC]  = ctl.src;
            rdata[CTL_IEN]  = ctl.ien;
            rdata[CTL_FREE] = ctl.freerun;
        end else if (sel_pre) begin
            rdata = 32'(pre_val);
        end else if (sel_cmp) begin
            rdata = 32'(cmp_val);
        end else if (sel_cnt) begin
            rdata = 32'(cnt);
        end else if (sel_sts) begin
            rdata[STS_CMP] = flag_q;
            rdata[STS_CAP] = 1'b0;
        end
    end

    // Level interrupt gated by the enable bit.
    always_comb irq = flag_q && ctl.ien;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !hit) |=> !flag_q); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q); // R9
endmodule

// File: rtl/cmp_timer.sv
// Top: compare-match interval timer. Connects the register file, the tick
// divider and the counter core. Assumes a single clock domain.
module cmp_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              ref_tick,
    output logic [31:0]       rdata,
    output logic              irq
);
    ctl_t             ctl;
    logic [PRE_W-1:0] pre_val;
    logic             pre_wr;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] cnt;
    logic             hit;
    logic             step;

    tmr_regs #(.ADDR_W(ADDR_W), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hit(hit), .cnt(cnt), .ctl(ctl), .pre_val(pre_val), .pre_wr(pre_wr),
        .cmp_val(cmp_val), .rdata(rdata), .irq(irq)
    );

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(ctl.en), .src_sel(ctl.src),
        .ref_tick(ref_tick), .div(pre_val), .restart(pre_wr), .step(step)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(ctl.en), .freerun(ctl.freerun),
        .step(step), .cmp(cmp_val), .cnt(cnt), .hit(hit)
    );

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ien |-> !irq); // R9
endmodule

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
    localparam int CW   = 10;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ref_tick = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cmp_timer #(.ADDR_W(5), .CNT_W(CW), .PRE_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ref_tick(ref_tick), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_all();
        wr(5'h00, 32'h0);
        wr(5'h04, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v); chk("R10 ctl", v, 0);
        rd(5'h10, v); chk("R10 cnt", v, 0);
        rd(5'h14, v); chk("R10 sts", v, 0);
        chk("R10 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(5'h08, 32'h123);
        wr(5'h04, 32'h5);
        wr(5'h10, 32'h77);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h08, v); chk("R2 compare", v, 32'h123);
        rd(5'h04, v); chk("R2 prescaler", v, 32'h5);
        rd(5'h10, v); chk("R2 counter read-only", v, 0);
        rd(5'h0C, v); chk("R2 unused offset", v, 0);
        wr(5'h00, 32'h113);
        rd(5'h00, v); chk("R2 control", v, 32'h113);
        stop_all();
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(5'h00, 32'h3);
        wait_n(8);
        stop_all();
        rd(5'h10, v); chk("R1 cleared", v, 0);
        wait_n(20);
        rd(5'h10, v); chk("R1 held", v, 0);
    endtask

    task automatic t_src();
        logic [31:0] v, v2;
        wr(5'h00, 32'h1);
        wait_n(10);
        rd(5'h10, v); chk("R3 ref idle", v, 0);
        ref_tick = 1'b1;
        wait_n(7);
        ref_tick = 1'b0;
        rd(5'h10, v); chk("R3 ref pulses", v, 7);
        wr(5'h00, 32'h3);
        rd(5'h10, v);
        wait_n(15);
        rd(5'h10, v2); chk("R3 clock source", v2, (v + 15) & MASK);
        stop_all();
    endtask

    task automatic t_pre();
        logic [31:0] v;
        wr(5'h04, 32'h3);
        wr(5'h00, 32'h3);
        wait_n(40);
        rd(5'h10, v); chk("R4 divide by 4", v, 10);
        stop_all();
        wr(5'h00, 32'h3);
        wait_n(40);
        rd(5'h10, v); chk("R4 divide by 1", v, 40);
        stop_all();
    endtask

    task automatic t_free();
        logic [31:0] v, c;
        wr(5'h08, 32'd20);
        wr(5'h14, 32'h1);
        wr(5'h00, 32'h103);
        wait_n(19);
        rd(5'h14, v); chk("R5 before match", v, 0);
        wait_n(1);
        rd(5'h14, v); chk("R5 at match", v, 1);
        chk("R9 gated irq", {31'b0, irq}, 0);
        wait_n(1);
        rd(5'h10, v); chk("R6 runs through", v, 21);
        wr(5'h00, 32'h113);
        chk("R9 irq level", {31'b0, irq}, 1);
        wr(5'h14, 32'h0);
        rd(5'h14, v); chk("R8 zero write", v, 1);
        wr(5'h14, 32'h1);
        rd(5'h14, v); chk("R8 cleared", v, 0);
        chk("R9 irq dropped", {31'b0, irq}, 0);
        rd(5'h10, v);
        wait_n(1000 - v);
        rd(5'h10, v);
        c = (v + 40) & MASK;
        wr(5'h08, c);
        wait_n(29);
        rd(5'h10, v); chk("R6 wrapped", v, (c - 10) & MASK);
        rd(5'h14, v); chk("R6 no early match", v, 0);
        wait_n(10);
        rd(5'h14, v); chk("R6 match past wrap", v, 1);
        stop_all();
        wr(5'h14, 32'h1);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        wr(5'h08, 32'd12);
        wr(5'h00, 32'h3);
        wait_n(12);
        rd(5'h10, v); chk("R7 reach compare", v, 12);
        rd(5'h14, v); chk("R7 flag", v, 1);
        wait_n(1);
        rd(5'h10, v); chk("R7 reload", v, 0);
        wait_n(1);
        rd(5'h10, v); chk("R7 resume", v, 1);
        wr(5'h14, 32'h1);
        wait_n(10);
        rd(5'h10, v); chk("R7 second pass", v, 12);
        rd(5'h14, v); chk("R7 second flag", v, 1);
        stop_all();
        wr(5'h14, 32'h1);
    endtask

    task automatic t_equal();
        logic [31:0] v;
        wr(5'h00, 32'h1);
        wr(5'h08, 32'h0);
        wr(5'h14, 32'h1);
        wait_n(10);
        rd(5'h14, v); chk("R5 equal no flag", v, 0);
        wr(5'h00, 32'h103);
        wait_n(MASK);
        rd(5'h14, v); chk("R5 not yet round", v, 0);
        wait_n(1);
        rd(5'h14, v); chk("R5 come round", v, 1);
        stop_all();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_map();
        t_disable();
        t_src();
        t_pre();
        t_free();
        t_restart();
        t_equal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule